// File: doc/BRIEF.md
# Single-Wire Debug Bit Host

This block is the host-side engine for one bit slot on a single-wire, open-drain debug line. Every slot is measured in target clock cycles. A target cycle is a programmable number of host clocks, so one host clock can serve targets that run at different speeds. A slot always begins with the host pulling the wire low. In a write slot, a short low period encodes a one and a long low period encodes a zero. Either low period ends with a one-cycle active high drive, which speeds up the rising edge instead of leaving it to the pull-up. In a read slot, the host pulls the wire low briefly and then releases it. It then captures whatever level the target leaves on the wire near the middle of the slot.

An upstream framer hands the block one bit request at a time: a read flag and a data bit, qualified by a valid strobe. While the slot runs, the block raises `busy`. When the slot ends, it pulses `done`. The last sampled read value stays on `rxBit`. The pad cell receives two separate enables, one that pulls the wire low and one that drives it high. The sensed wire level returns on `pinIn`. A new request may be accepted on the final clock of the current slot, so bits can run back to back with no idle gap.

Top module: `owbit_host`

## Requirements
- R1: During and after reset, with no request, `busy`, `done`, `driveLow`, `driveHigh` and `rxBit` are all 0.
- R2: One target cycle lasts `divRatio`+1 host clocks. `divRatio` is captured when a request is accepted, so a change during a slot does not alter that slot's timing.
- R3: A write slot with `reqData`=1 asserts `driveLow` for target cycles 0 to 3. It asserts `driveHigh` for target cycle 4 only and drives nothing for the rest of the slot.
- R4: A write slot with `reqData`=0 asserts `driveLow` for target cycles 0 to 12. It asserts `driveHigh` for target cycle 13 only and drives nothing for the rest of the slot.
- R5: A read slot (`reqRead`=1) asserts `driveLow` for target cycles 0 and 1, then releases the wire. It never asserts `driveHigh`.
- R6: A read slot captures `pinIn` into `rxBit` on the host clock edge that ends target cycle 9, which is ten target cycles after the slot start. `rxBit` then holds until the next read capture, and write slots leave it unchanged.
- R7: `busy` rises on the clock after acceptance and lasts exactly 16 target cycles. `done` is a single-clock pulse on the clock that follows the slot's last edge.
- R8: A request is accepted when `reqValid` is high and the block is either idle or on the final edge of a slot. In the second case the next slot starts with no gap, `busy` stays high and `done` still pulses. A request presented at any other time while busy is ignored.
- R9: `driveLow` and `driveHigh` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset |
| divRatio | input | DIV_W | Host clocks per target cycle, minus one |
| reqValid | input | 1 | Bit request strobe |
| reqRead | input | 1 | 1 = read slot, 0 = write slot |
| reqData | input | 1 | Bit value for a write slot |
| pinIn | input | 1 | Sensed level of the debug wire |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-clock pulse after a slot ends |
| rxBit | output | 1 | Last value captured in a read slot |
| driveLow | output | 1 | Pad enable: pull the wire low |
| driveHigh | output | 1 | Pad enable: drive the wire high (speedup) |

## Verification
The end of one slot and the acceptance of the next can land on the same host clock edge. On that edge `done` must pulse, `busy` must stay high, and the new slot's low drive must start together. The bench provokes this by holding a read request on the last clock of a write-one slot. It checks `done`, `busy` and `driveLow` on the following clock. It then counts the full length of the second slot and checks the bit that slot captured. Requests placed in the middle of a slot are checked the same way. The slot's drive pattern must come out unchanged and no extra slot may follow.

// File: rtl/owbit_pkg.sv
package owbit_pkg;

  typedef enum logic [1:0] {
    OP_WR0 = 2'd0,
    OP_WR1 = 2'd1,
    OP_RD  = 2'd2
  } owbit_op_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;    // capture divider, restart prescaler
    logic run;     // slot in progress, prescaler counting
    logic sample;  // capture pin level this edge
    logic low;     // pull wire low
    logic high;    // drive wire high
  } owbit_strb_t;

endpackage

// File: rtl/owbit_dp.sv
module owbit_dp
  import owbit_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             pinIn,
  input  owbit_strb_t      strb,
  output logic             tick,
  output logic             rxBit,
  output logic             driveLow,
  output logic             driveHigh
);

  logic [DIV_W-1:0] divLat;
  logic [DIV_W-1:0] preCnt;

  assign tick = strb.run && (preCnt == divLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLat <= '0;
      preCnt <= '0;
    end else if (strb.load) begin
      divLat <= divRatio;
      preCnt <= '0;
    end else if (strb.run) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rxBit <= 1'b0;
    else if (strb.sample) rxBit <= pinIn;
  end

  assign driveLow  = strb.low;
  assign driveHigh = strb.high;

  AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(driveLow && driveHigh)); // R9

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.load) |=> $stable(divLat)); // R2

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (preCnt <= divLat)); // R2

endmodule

// File: rtl/owbit_ctrl.sv
module owbit_ctrl
  import owbit_pkg::*;
#(
  parameter int BIT_LEN   = 16,
  parameter int LOW_ONE   = 4,
  parameter int LOW_ZERO  = 13,
  parameter int LOW_READ  = 2,
  parameter int SAMPLE_AT = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic        reqData,
  input  logic        tick,
  output owbit_strb_t strb,
  output logic        busy,
  output logic        done
);

  localparam int CYC_W = $clog2(BIT_LEN);

  logic [CYC_W-1:0] cyc;
  owbit_op_e        op;
  logic [CYC_W-1:0] lowEnd;
  logic             lastEdge;
  logic             accept;

  assign lastEdge = busy && tick && (cyc == CYC_W'(BIT_LEN - 1));
  assign accept   = reqValid && (!busy || lastEdge);

  always_comb begin
    unique case (op)
      OP_RD:   lowEnd = CYC_W'(LOW_READ);
      OP_WR1:  lowEnd = CYC_W'(LOW_ONE);
      default: lowEnd = CYC_W'(LOW_ZERO);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cyc  <= '0;
      op   <= OP_WR0;
    end else begin
      done <= lastEdge;
      if (accept) begin
        busy <= 1'b1;
        cyc  <= '0;
        op   <= reqRead ? OP_RD : (reqData ? OP_WR1 : OP_WR0);
      end else if (lastEdge) begin
        busy <= 1'b0;
        cyc  <= '0;
      end else if (busy && tick) begin
        cyc  <= cyc + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.run    = busy;
    strb.sample = busy && (op == OP_RD) && tick && (cyc == CYC_W'(SAMPLE_AT - 1));
    strb.low    = busy && (cyc < lowEnd);
    strb.high   = busy && (op != OP_RD) && (cyc == lowEnd);
  end

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy)); // R7

  AST_READ_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && op == OP_RD) |-> !strb.high); // R5

  AST_WRITE_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && op != OP_RD) |-> !strb.sample); // R6

  AST_IGNORE_MIDSLOT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastEdge) |=> $stable(op)); // R8

endmodule

// File: rtl/owbit_host.sv
module owbit_host
  import owbit_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             reqValid,
  input  logic             reqRead,
  input  logic             reqData,
  input  logic             pinIn,
  output logic             busy,
  output logic             done,
  output logic             rxBit,
  output logic             driveLow,
  output logic             driveHigh
);

  owbit_strb_t strb;
  logic        tick;

  owbit_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqRead  (reqRead),
    .reqData  (reqData),
    .tick     (tick),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  owbit_dp #(.DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .divRatio  (divRatio),
    .pinIn     (pinIn),
    .strb      (strb),
    .tick      (tick),
    .rxBit     (rxBit),
    .driveLow  (driveLow),
    .driveHigh (driveHigh)
  );

endmodule

// File: tb/sim_owbit_host.sv
module sim_owbit_host;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] divRatio;
  logic       reqValid, reqRead, reqData;
  logic       tgtLevel;
  logic       pinIn;
  logic       busy, done, rxBit, driveLow, driveHigh;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign pinIn = driveLow ? 1'b0 : tgtLevel;

  owbit_host u0 (
    .clk(clk), .rstN(rstN), .divRatio(divRatio),
    .reqValid(reqValid), .reqRead(reqRead), .reqData(reqData),
    .pinIn(pinIn), .busy(busy), .done(done), .rxBit(rxBit),
    .driveLow(driveLow), .driveHigh(driveHigh)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // R1
  task automatic tReset();
    rstN = 1'b0; reqValid = 0; reqRead = 0; reqData = 0; divRatio = 0; tgtLevel = 1;
    repeat (3) @(negedge clk);
    check({busy, done, rxBit, driveLow, driveHigh} == 5'b0, "R1 in reset",
          {busy, done, rxBit, driveLow, driveHigh}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({busy, done, rxBit, driveLow, driveHigh} == 5'b0, "R1 after reset",
          {busy, done, rxBit, driveLow, driveHigh}, 0);
  endtask

  // one slot; kind 0=wr0 1=wr1 2=rd; noise: mid-slot request; divNoise: divider change
  task automatic tSlot(input int kind, input int d, input bit tgt,
                       input bit noise, input bit divNoise, input string req);
    int p = d + 1;
    int lowLen = (kind == 2) ? 2 : (kind == 1 ? 4 : 13);
    int total = 16 * p;
    int eLow = 0, eHigh = 0, eBusy = 0, eDone = 0;
    int aLow = 0, aHigh = 0, aBusy = 0, aDone = 0;
    bit rxBefore = rxBit;
    @(negedge clk);
    divRatio = 8'(d); reqValid = 1; reqRead = (kind == 2); reqData = (kind == 1);
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i <= total + 2; i++) begin
      tgtLevel = (i == 10 * p - 1) ? tgt : ~tgt;
      if (noise) begin
        reqValid = (i == 3 || i == 4);
        reqRead = 1; reqData = 1;
      end
      if (divNoise && i == 2) divRatio = 8'(d + 3);
      if (driveLow  != (i < lowLen * p)) begin eLow++;  aLow = i; end
      if (driveHigh != (kind != 2 && i >= lowLen * p && i < (lowLen + 1) * p)) begin
        eHigh++; aHigh = i; end
      if (busy != (i < total)) begin eBusy++; aBusy = i; end
      if (done != (i == total)) begin eDone++; aDone = i; end
      @(negedge clk);
    end
    reqValid = 0; tgtLevel = 1;
    check(eLow == 0,  {req, " driveLow"},  aLow,  lowLen * p);
    check(eHigh == 0, {req, " driveHigh"}, aHigh, lowLen * p);
    check(eBusy == 0, {req, " busy length (R7)"}, aBusy, total);
    check(eDone == 0, {req, " done pulse (R7)"}, aDone, total);
    if (kind == 2) check(rxBit == tgt, {req, " R6 sampled bit"}, rxBit, tgt);
    else           check(rxBit == rxBefore, {req, " R6 rxBit held on write"}, rxBit, rxBefore);
  endtask

  // R8: back-to-back acceptance on the final edge
  task automatic tBackToBack(input int d);
    int p = d + 1;
    int cnt = 0;
    @(negedge clk);
    divRatio = 8'(d); reqValid = 1; reqRead = 0; reqData = 1;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 16 * p - 1; i++) @(negedge clk);
    reqValid = 1; reqRead = 1; reqData = 0;   // present on the last edge
    tgtLevel = 1;
    @(negedge clk);
    reqValid = 0;
    check(done == 1'b1, "R8 done on back-to-back", done, 1);
    check(busy == 1'b1, "R8 busy kept high", busy, 1);
    check(driveLow == 1'b1, "R8 next slot low at once", driveLow, 1);
    for (int i = 0; i < 20 * p && busy; i++) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == 16 * p, "R8 second slot length", cnt, 16 * p);
    check(rxBit == 1'b1, "R8 second slot read value", rxBit, 1);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R8 no extra slot", busy, 0);
  endtask

  initial begin
    tReset();
    tSlot(1, 0, 0, 0, 0, "R3 write1 d0");
    tSlot(0, 0, 0, 0, 0, "R4 write0 d0");
    tSlot(2, 0, 1, 0, 0, "R5 read1 d0");
    tSlot(1, 2, 0, 0, 0, "R3 write1 d2");
    tSlot(2, 1, 0, 0, 0, "R5 read0 d1");
    tSlot(0, 3, 1, 0, 0, "R4 write0 d3");
    tSlot(2, 3, 1, 0, 0, "R6 read1 d3");
    tSlot(1, 1, 0, 1, 0, "R8 ignored mid-slot request");
    tSlot(0, 2, 0, 0, 1, "R2 divider change mid-slot");
    tSlot(2, 2, 0, 0, 1, "R2 read with divider change");
    tBackToBack(1);
    check(!(driveLow && driveHigh), "R9 drives exclusive", driveLow, 0);
    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

endmodule